// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page to a real page by searching an in-memory hashed page table. A request carries the low 28 bits of an effective address (the offset inside its 256 MB segment), the 24-bit virtual segment identifier taken from the segment register, and a load/store flag. The walker hashes the identifier with the page index and reads the eight 8-byte entries of the selected group one at a time. If none of them matches, it repeats the search on a second group chosen by the bit-inverted hash.

A hit returns both entry words and the real address. When the access changes the entry's usage bits, the walker also writes back the entry's second word. The referenced bit is set on every hit, and the changed bit is set on stores. A load hit is reported without write permission, so that a later store walks the table again and marks the page changed. If both groups miss, the walker reports not-found. The table base and the group-index mask are inputs and must stay stable during a walk. Permission checking and TLB storage belong to the surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: The primary group address is `tbl_base + ((H << 6) & tbl_mask)`, where H = VSID XOR ea[27:12] (the page index, zero-extended to 32 bits). The entries of a group are read at group+0, +8, … +56, in that order.
- R2: An entry matches when word0 bit 31 (valid) is 1, word0 bit 6 (hash-select) equals the search phase (0 primary, 1 secondary), word0 bits 30..7 equal the VSID and word0 bits 5..0 equal ea[27:22]. Entry data arrives as {word0, word1} on the 64-bit read response.
- R3: Only after all eight primary entries miss is the secondary group searched, at `tbl_base + ((~H << 6) & tbl_mask)`.
- R4: The walk stops at the first matching entry, so the number of entry reads equals the matching entry's position in search order.
- R5: If both groups miss, the result reports hit=0 after exactly 16 entry reads, and nothing is written.
- R6: On a hit, the new word1 is the old word1 with bit 8 (referenced) set, and with bit 7 (changed) also set for a store. The new word1 is written to entry address + 4 only if it differs from the old word1. It is also returned as `res_w1`.
- R7: On a hit, `res_ra` = {word1[31:12], ea[11:0]}.
- R8: `res_wr_ok` is 1 only for a store that hits. Load hits and misses give 0.
- R9: At most one read is outstanding. A read request holds its address stable until it is accepted.
- R10: After reset the walker is idle: `req_ready`=1, and `res_valid`, `mem_req_valid` and `mem_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and accepting |
| req_ea | input | 28 | Effective address within segment |
| req_vsid | input | 24 | Virtual segment identifier |
| req_store | input | 1 | Access is a store |
| tbl_base | input | 32 | Page table base address |
| tbl_mask | input | 32 | Group offset mask |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | {word0, word1} of the entry |
| mem_wr_valid | output | 1 | Word1 write-back request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | 32 | Word1 byte address |
| mem_wr_data | output | 32 | Updated word1 |
| res_valid | output | 1 | Result pulse, one cycle |
| res_hit | output | 1 | Translation found |
| res_w0 | output | 32 | Matching entry word0 |
| res_w1 | output | 32 | Updated word1 |
| res_ra | output | 32 | Real address |
| res_wr_ok | output | 1 | Write permission may be granted |

## Verification
The bench places a matching entry whose hash-select bit is wrong in the primary group, and an entry with the valid bit clear but a matching tag. A walker that ignored either bit would stop early, with a short read count or the wrong page. It plants two matches in one group to expose a design that keeps scanning and returns the later entry. It also runs a narrow mask where the inverted hash wraps, which catches a secondary address formed without the complement or without masking. Store and load hits with the usage bits already set show whether a redundant write-back is issued, or whether a load hit grants write permission.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [27:0] req_ea,
  input  logic [23:0] req_vsid,
  input  logic        req_store,
  input  logic [31:0] tbl_base,
  input  logic [31:0] tbl_mask,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data,
  output logic        res_valid,
  output logic        res_hit,
  output logic [31:0] res_w0,
  output logic [31:0] res_w1,
  output logic [31:0] res_ra,
  output logic        res_wr_ok
);
  localparam int IDX_W  = $clog2(GROUP_ENTRIES);
  localparam int GRP_SH = $clog2(GROUP_ENTRIES * 8);
  localparam int CNT_W  = IDX_W + 2;
  localparam logic [CNT_W-1:0] ALL_EXAMS = CNT_W'(2 * GROUP_ENTRIES);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WB, S_DONE} state_t;
  state_t st;

  logic [27:0]      ea_q;
  logic [23:0]      vsid_q;
  logic             store_q, phase, hit_q;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] exam_cnt;
  logic [31:0]      w0_q, w1_q;

  wire [15:0] pg    = ea_q[27:12];
  wire [31:0] hash  = {8'b0, vsid_q ^ {8'b0, pg}};
  wire [31:0] hsel  = phase ? ~hash : hash;
  wire [31:0] grp   = tbl_base + ((hsel << GRP_SH) & tbl_mask);
  wire [31:0] rw0   = mem_rsp_data[63:32];
  wire [31:0] rw1   = mem_rsp_data[31:0];
  wire        match = rw0[31] && (rw0[6] == phase) &&
                      ({rw0[30:7], rw0[5:0]} == {vsid_q, pg[15:10]});
  wire [31:0] w1_new = rw1 | 32'h100 | (store_q ? 32'h80 : 32'h0);
  wire        last   = (idx == IDX_W'(GROUP_ENTRIES - 1));

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD);
  assign mem_req_addr  = grp + (32'(idx) << 3);
  assign mem_wr_valid  = (st == S_WB);
  assign mem_wr_addr   = mem_req_addr + 32'd4;
  assign mem_wr_data   = w1_q;
  assign res_valid     = (st == S_DONE);
  assign res_hit       = hit_q;
  assign res_w0        = w0_q;
  assign res_w1        = w1_q;
  assign res_ra        = {w1_q[31:12], ea_q[11:0]};
  assign res_wr_ok     = hit_q & store_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ea_q <= '0; vsid_q <= '0; store_q <= 1'b0;
      phase <= 1'b0; hit_q <= 1'b0; idx <= '0; exam_cnt <= '0;
      w0_q <= '0; w1_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q <= req_ea; vsid_q <= req_vsid; store_q <= req_store;
          phase <= 1'b0; idx <= '0; exam_cnt <= '0; hit_q <= 1'b0;
          st <= S_RD;
        end
        S_RD: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          exam_cnt <= exam_cnt + 1'b1;
          if (match) begin
            hit_q <= 1'b1; w0_q <= rw0; w1_q <= w1_new;
            st <= (w1_new != rw1) ? S_WB : S_DONE;
          end else if (!last) begin
            idx <= idx + 1'b1; st <= S_RD;
          end else if (!phase) begin
            phase <= 1'b1; idx <= '0; st <= S_RD;
          end else begin
            st <= S_DONE;
          end
        end
        S_WB: if (mem_wr_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  a_r1_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == tbl_base[2:0]);
  a_r5_miss_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> exam_cnt == ALL_EXAMS);
  a_r6_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> mem_wr_data[8] && hit_q);
  a_r8_wr_ok_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_wr_ok |-> res_hit);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && req_ready);
endmodule

// File: tb/hpt_walker_tb_top.sv
module hpt_walker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [27:0] req_ea = '0;
  logic [23:0] req_vsid = '0;
  logic [31:0] tbl_base = '0, tbl_mask = '0;
  logic        mem_req_valid, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        res_valid, res_hit, res_wr_ok;
  logic [31:0] res_w0, res_w1, res_ra;

  hpt_walker dut_i (.*);

  logic [63:0] mem [int unsigned];
  int rd_total = 0, wb_total = 0, viol = 0, cyc = 0;
  logic [31:0] last_wb_addr = '0, last_wb_data = '0;
  logic pend = 1'b0;
  logic [1:0] dly = '0;
  logic [31:0] paddr = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_wr_ready  <= (cyc % 2) == 0;
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(paddr) ? mem[paddr] : 64'h0;
        pend <= 1'b0;
      end else dly <= dly - 1'b1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (pend) viol <= viol + 1;
      pend <= 1'b1; dly <= 2'd1; paddr <= mem_req_addr;
      rd_total <= rd_total + 1;
    end
    if (mem_wr_valid && mem_wr_ready) begin
      wb_total <= wb_total + 1;
      last_wb_addr <= mem_wr_addr; last_wb_data <= mem_wr_data;
    end
  end

  int n_chk = 0, n_fail = 0, n_done = 0;
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic hit; logic [31:0] ra, w1; logic wb; logic [31:0] wb_addr;
    int reads; logic wrok; int rd_snap, wb_snap; string name;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) if (rst_n && res_valid) begin
    exp_t e;
    if (q.size() == 0) chk("R4 unexpected result", 1, 0);
    else begin
      e = q.pop_front();
      chk({"R2/R3 hit ", e.name}, res_hit, e.hit);
      chk({"R4/R5 reads ", e.name}, rd_total - e.rd_snap, e.reads);
      chk({"R8 wr_ok ", e.name}, res_wr_ok, e.wrok);
      chk({"R6 wb count ", e.name}, wb_total - e.wb_snap, e.wb ? 1 : 0);
      if (e.hit) begin
        chk({"R7 ra ", e.name}, res_ra, e.ra);
        chk({"R6 w1 ", e.name}, res_w1, e.w1);
      end
      if (e.wb) begin
        chk({"R6 wb addr ", e.name}, last_wb_addr, e.wb_addr);
        chk({"R6 wb data ", e.name}, last_wb_data, e.w1);
      end
    end
    n_done++;
  end

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [27:0] ea,
                                      input logic ph);
    logic [31:0] h;
    h = {8'b0, v ^ {8'b0, ea[27:12]}};
    if (ph) h = ~h;
    return tbl_base + ((h << 6) & tbl_mask);
  endfunction

  function automatic logic [31:0] w0f(input logic [23:0] v, input logic [27:0] ea,
                                      input logic h, input logic vld);
    return {vld, v, h, ea[27:22]};
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a] = {w0, w1};
  endtask

  task automatic walk(input string name, input logic [23:0] v, input logic [27:0] ea,
                      input logic store, input logic hit, input int reads,
                      input logic [31:0] w1_old, input logic [31:0] ent_addr);
    exp_t e;
    e.name = name; e.hit = hit; e.reads = reads;
    e.w1 = w1_old | 32'h100 | (store ? 32'h80 : 32'h0);
    e.wb = hit && (e.w1 != w1_old);
    e.wb_addr = ent_addr + 4;
    e.ra = {w1_old[31:12], ea[11:0]};
    e.wrok = hit && store;
    e.rd_snap = rd_total; e.wb_snap = wb_total;
    q.push_back(e);
    @(negedge clk);
    req_vsid = v; req_ea = ea; req_store = store; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    report();
  end

  initial begin
    logic [23:0] v;
    logic [27:0] ea;
    logic [31:0] g;
    repeat (3) @(negedge clk);
    chk("R10 req_ready after reset", req_ready, 1);
    chk("R10 res_valid after reset", res_valid, 0);
    chk("R10 mem_req_valid after reset", mem_req_valid, 0);
    chk("R10 mem_wr_valid after reset", mem_wr_valid, 0);
    rst_n = 1'b1;
    tbl_base = 32'h0010_0000; tbl_mask = 32'h000F_FFC0;
    v = 24'h123456; ea = 28'hABCD123;

    // R1 R6 R7: primary slot 0, load, referenced bit set by write-back
    g = grp(v, ea, 0);
    put(g, w0f(v, ea, 0, 1), 32'h0ABC5002);
    walk("load slot0", v, ea, 0, 1, 1, 32'h0ABC5002, g);
    mem.delete();

    // R4 R6: slot 5, referenced already set, no write-back
    put(g + 40, w0f(v, ea, 0, 1), 32'h11111100);
    walk("load slot5 no wb", v, ea, 0, 1, 6, 32'h11111100, g + 40);
    mem.delete();

    // R6 R8: store sets changed bit
    put(g + 24, w0f(v, ea, 0, 1), 32'h22222100);
    walk("store slot3", v, ea, 1, 1, 4, 32'h22222100, g + 24);
    mem.delete();

    // R2 R3: wrong hash-select in primary, hit in secondary slot 2
    put(g + 8, w0f(v, ea, 1, 1), 32'h99999000);
    put(grp(v, ea, 1) + 16, w0f(v, ea, 1, 1), 32'h33333000);
    walk("secondary slot2", v, ea, 0, 1, 11, 32'h33333000, grp(v, ea, 1) + 16);
    mem.delete();

    // R2 R5: wrong page bits and invalid match -> full miss
    put(g, {1'b1, v, 1'b0, ~ea[27:22]}, 32'h77777000);
    put(g + 8, w0f(v, ea, 0, 0), 32'h77777000);
    put(grp(v, ea, 1), w0f(v, ea, 0, 1), 32'h77777000);
    walk("full miss", v, ea, 1, 0, 16, 32'h0, 32'h0);
    mem.delete();

    // R6 R8: store with both bits already set, no write-back
    put(g, w0f(v, ea, 0, 1), 32'h44444180);
    walk("store no wb", v, ea, 1, 1, 1, 32'h44444180, g);
    mem.delete();

    // R4: first of two matches wins
    put(g + 8, w0f(v, ea, 0, 1), 32'h55555000);
    put(g + 32, w0f(v, ea, 0, 1), 32'h66666000);
    walk("first match", v, ea, 0, 1, 2, 32'h55555000, g + 8);
    mem.delete();

    // R1 R3: narrow mask, complemented hash, secondary last slot
    tbl_base = 32'h0008_0000; tbl_mask = 32'h0000_3FC0;
    v = 24'hF0F0F0; ea = 28'h5A5A5FF;
    put(grp(v, ea, 1) + 56, w0f(v, ea, 1, 1), 32'hCAFE1000);
    walk("narrow mask secondary", v, ea, 1, 1, 16, 32'hCAFE1000, grp(v, ea, 1) + 56);
    mem.delete();

    chk("R9 single outstanding read", viol, 0);
    chk("R10 results seen", n_done, 8);
    report();
  end
endmodule